// File: doc/BRIEF.md
# Thirty-Two-Bit Arithmetic-Logic Unit with Zero Flag

This block is the purely combinational execution unit of a small single-issue integer datapath. It takes two operands and a four-bit operation code. It returns one word of result and a flag that reports whether that word is all zeros. The unit covers three bitwise functions (AND, OR, NOR), wrap-around addition and subtraction, and a signed less-than comparison whose result is a single bit. Branch logic can use the flag directly, for example to test the result of a subtraction for equality.

Carry-out and signed overflow are computed internally only where the comparison needs them, and they are never exposed. An operation code outside the supported set gives a result of all zeros. The behaviour is therefore fully defined for every input. The operand width is a parameter that defaults to 32 bits. Two more parameters pick the adder structure and the zero-detector structure.

Top module: `alu32_zf`

## Requirements
- R1: Operation code 4'b0000 drives the result with the bitwise AND of `opa` and `opb`.
- R2: Operation code 4'b0001 drives the result with the bitwise OR of `opa` and `opb`.
- R3: Operation code 4'b0010 drives the result with `opa + opb` modulo 2^32; the carry out of bit 31 is dropped.
- R4: Operation code 4'b0110 drives the result with `opa - opb` modulo 2^32.
- R5: Operation code 4'b1100 drives the result with the bitwise complement of (`opa` OR `opb`).
- R6: Operation code 4'b0111 drives result bit 0 with 1 when `opa` is less than `opb` as signed two's-complement numbers, and with 0 otherwise; result bits 31..1 are always 0 for this code.
- R7: The less-than result of R6 stays correct when the operands have opposite signs and their difference overflows, e.g. 0x7FFFFFFF vs 0x80000000 gives 0 and 0x80000000 vs 0x00000001 gives 1.
- R8: Every operation code other than the six above (e.g. 4'b0011, 4'b1000, 4'b1111) drives a result of all zeros.
- R9: `zero` is 1 exactly when all 32 result bits are 0, for every operation code, including the unlisted ones of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand (minuend for subtraction, left side of the comparison) |
| opb | input | 32 | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Result word |
| zero | output | 1 | High when `result` is all zeros |

## Verification
The zero flag interacts with every arithmetic function in the same evaluation. The vectors that matter most are the ones where an arithmetic function and the flag agree on an all-zero word. Subtracting equal operands, adding a value to its negation so that the sum wraps to zero, a less-than test that comes out false, and an unlisted code are all applied on purpose. In each case the bench requires `zero` to rise together with the all-zero result. Overflowing subtractions inside the comparison are provoked with extreme opposite-sign operands. They are judged against a signed comparison that the reference model computes independently of any difference.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

   localparam int ALU_SEL_W = 4;

   typedef enum logic [ALU_SEL_W-1:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111,
      ALU_NOR = 4'b1100
   } alu_op_e;

   // Adder structure choice
   localparam int ADDER_BEHAV  = 0;
   localparam int ADDER_RIPPLE = 1;

   // Width of each slice in the tree zero detector
   localparam int ZERO_SLICE_W = 8;

endpackage

// File: rtl/alu32_logic.sv
module alu32_logic #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] and_o,
   output logic [W-1:0] or_o,
   output logic [W-1:0] nor_o
);

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_bit
         assign and_o[gi] = a[gi] & b[gi];
         assign or_o[gi]  = a[gi] | b[gi];
         assign nor_o[gi] = ~(a[gi] | b[gi]);
      end
   endgenerate

endmodule

// File: rtl/alu32_addsub.sv
module alu32_addsub
   import alu32_pkg::*;
#(
   parameter int W    = 32,
   parameter int ARCH = ADDER_BEHAV
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         ovf
);

   localparam int MSB = W - 1;

   logic [W-1:0] b_eff;
   assign b_eff = b ^ {W{sub}};

   generate
      if (ARCH == ADDER_RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = sub;
         for (genvar gi = 0; gi < W; gi++) begin : g_cell
            logic p;
            assign p          = a[gi] ^ b_eff[gi];
            assign sum[gi]    = p ^ cy[gi];
            assign cy[gi + 1] = (a[gi] & b_eff[gi]) | (p & cy[gi]);
         end
         // Signed overflow: carries into and out of the top bit differ
         assign ovf = cy[W] ^ cy[MSB];
      end else begin : g_behav
         assign sum = a + b_eff + {{(W-1){1'b0}}, sub};
         assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
      end
   endgenerate

endmodule

// File: rtl/alu32_zero.sv
module alu32_zero
   import alu32_pkg::*;
#(
   parameter int W    = 32,
   parameter bit TREE = 1'b1
) (
   input  logic [W-1:0] v,
   output logic         is_zero
);

   localparam int NSLICE = W / ZERO_SLICE_W;

   generate
      if (TREE) begin : g_tree
         logic [NSLICE-1:0] slice_clr;
         for (genvar gs = 0; gs < NSLICE; gs++) begin : g_slice
            assign slice_clr[gs] = ~|v[gs*ZERO_SLICE_W +: ZERO_SLICE_W];
         end
         assign is_zero = &slice_clr;
      end else begin : g_flat
         assign is_zero = ~|v;
      end
   endgenerate

endmodule

// File: rtl/alu32_zf.sv
module alu32_zf
   import alu32_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ADDER_ARCH = ADDER_BEHAV,
   parameter bit ZERO_TREE  = 1'b1
) (
   input  logic [WIDTH-1:0]     opa,
   input  logic [WIDTH-1:0]     opb,
   input  logic [ALU_SEL_W-1:0] op_sel,
   output logic [WIDTH-1:0]     result,
   output logic                 zero
);

   localparam int MSB = WIDTH - 1;

   // Elaboration-time parameter checks
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu32_zf: WIDTH must be at least 2");
      end
      if (ZERO_TREE && (WIDTH % ZERO_SLICE_W != 0)) begin : g_bad_tree
         $error("alu32_zf: tree zero detector needs WIDTH divisible by slice width");
      end
      if (ADDER_ARCH != ADDER_BEHAV && ADDER_ARCH != ADDER_RIPPLE) begin : g_bad_arch
         $error("alu32_zf: unknown ADDER_ARCH");
      end
   endgenerate

   logic [WIDTH-1:0] and_w, or_w, nor_w, sum_w;
   logic             ovf_w;
   logic             sub_mode;
   logic             lt_bit;

   // Subtraction is shared by difference and comparison
   assign sub_mode = (op_sel == ALU_SUB) || (op_sel == ALU_SLT);

   alu32_logic #(.W(WIDTH)) u_logic (
      .a     (opa),
      .b     (opb),
      .and_o (and_w),
      .or_o  (or_w),
      .nor_o (nor_w)
   );

   alu32_addsub #(.W(WIDTH), .ARCH(ADDER_ARCH)) u_addsub (
      .a   (opa),
      .b   (opb),
      .sub (sub_mode),
      .sum (sum_w),
      .ovf (ovf_w)
   );

   // Signed less-than: sign of the difference corrected by overflow
   assign lt_bit = sum_w[MSB] ^ ovf_w;

   always_comb begin
      case (op_sel)
         ALU_AND: result = and_w;
         ALU_OR:  result = or_w;
         ALU_NOR: result = nor_w;
         ALU_ADD: result = sum_w;
         ALU_SUB: result = sum_w;
         ALU_SLT: result = {{(WIDTH-1){1'b0}}, lt_bit};
         default: result = '0;
      endcase
   end

   alu32_zero #(.W(WIDTH), .TREE(ZERO_TREE)) u_zero (
      .v       (result),
      .is_zero (zero)
   );

endmodule

// File: rtl/alu32_zf_checker.sv
module alu32_zf_checker
   import alu32_pkg::*;
#(
   parameter int W = 32
) (
   input logic [W-1:0]         opa,
   input logic [W-1:0]         opb,
   input logic [ALU_SEL_W-1:0] op_sel,
   input logic [W-1:0]         result,
   input logic                 zero
);

   logic known_op;
   assign known_op = (op_sel == ALU_AND) || (op_sel == ALU_OR) || (op_sel == ALU_ADD) ||
                     (op_sel == ALU_SUB) || (op_sel == ALU_SLT) || (op_sel == ALU_NOR);

   always_comb begin
      if (op_sel == ALU_AND) begin
         p_and_within_operands_r1: assert (((result & ~opa) | (result & ~opb)) == '0)
            else $error("AND result has bits outside an operand");
      end
      if (op_sel == ALU_OR) begin
         p_or_covers_operands_r2: assert (((opa | opb) & ~result) == '0)
            else $error("OR result misses an operand bit");
      end
      if (op_sel == ALU_ADD) begin
         p_add_inverts_r3: assert ((result - opb) == opa)
            else $error("sum minus second operand is not the first operand");
      end
      if (op_sel == ALU_SUB) begin
         p_sub_inverts_r4: assert ((result + opb) == opa)
            else $error("difference plus second operand is not the first operand");
      end
      if (op_sel == ALU_NOR) begin
         p_nor_disjoint_r5: assert ((result & (opa | opb)) == '0)
            else $error("NOR result overlaps an operand bit");
      end
      if (op_sel == ALU_SLT) begin
         p_slt_single_bit_r6: assert (result[W-1:1] == '0)
            else $error("less-than result uses upper bits");
         p_slt_signed_r7: assert (result[0] == ($signed(opa) < $signed(opb)))
            else $error("less-than result disagrees with signed order");
      end
      if (!known_op) begin
         p_unlisted_clear_r8: assert (result == '0)
            else $error("unlisted code gave a nonzero result");
      end
      p_zero_flag_r9: assert (zero == (result == '0))
         else $error("zero flag disagrees with result");
   end

endmodule

bind alu32_zf alu32_zf_checker #(.W(WIDTH)) u_chk (
   .opa    (opa),
   .opb    (opb),
   .op_sel (op_sel),
   .result (result),
   .zero   (zero)
);

// File: tb/alu32_zf_bench.sv
module alu32_zf_bench;
   import alu32_pkg::*;

   logic        clk;
   logic [31:0] opa, opb;
   logic [3:0]  op_sel;
   logic [31:0] result;
   logic        zero;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  op;
      logic [31:0] exp_res;
      logic        exp_z;
      string       tag;
   } item_t;

   item_t sb_q[$];

   alu32_zf u_alu32_zf (
      .opa    (opa),
      .opb    (opb),
      .op_sel (op_sel),
      .result (result),
      .zero   (zero)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   // Reference model from the requirements
   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic [3:0] op);
      case (op)
         4'b0000: return a & b;                       // R1
         4'b0001: return a | b;                       // R2
         4'b0010: return a + b;                       // R3
         4'b0110: return a - b;                       // R4
         4'b1100: return ~(a | b);                    // R5
         4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; // R6, R7
         default: return 32'd0;                       // R8
      endcase
   endfunction

   task automatic drive(input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] op, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      opa    = a;
      opb    = b;
      op_sel = op;
      it.a       = a;
      it.b       = b;
      it.op      = op;
      it.exp_res = model(a, b, op);
      it.exp_z   = (it.exp_res == 32'd0);
      it.tag     = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: one result compared per cycle, half a period after drive
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (result !== it.exp_res || zero !== it.exp_z) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h: actual result=%h zero=%b expected result=%h zero=%b",
                     it.tag, it.op, it.a, it.b, result, zero, it.exp_res, it.exp_z);
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      logic [3:0] codes [8];
      codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0010; codes[3] = 4'b0110;
      codes[4] = 4'b1100; codes[5] = 4'b0111; codes[6] = 4'b0011; codes[7] = 4'b1111;
      opa = '0; opb = '0; op_sel = '0;

      // Idle state: all-zero inputs
      drive(32'h0, 32'h0, 4'b0000, "R9 idle");

      drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, "R1");
      drive(32'hAAAA_AAAA, 32'h5555_5555, 4'b0000, "R1 R9 disjoint");
      drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, "R2");
      drive(32'h1234_5678, 32'h1111_1111, 4'b0010, "R3");
      drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, "R3 R9 wrap to zero");
      drive(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, "R3 overflow dropped");
      drive(32'h0000_0005, 32'h0000_0007, 4'b0110, "R4 negative");
      drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110, "R4 R9 equal");
      drive(32'h0000_0000, 32'h0000_0000, 4'b1100, "R5 all ones");
      drive(32'hFFFF_0000, 32'h0000_FFFF, 4'b1100, "R5 R9 zero");
      drive(32'h0000_0003, 32'h0000_0009, 4'b0111, "R6 less");
      drive(32'h0000_0009, 32'h0000_0003, 4'b0111, "R6 R9 not less");
      drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0111, "R6 negative vs positive");
      drive(32'h0000_0004, 32'h0000_0004, 4'b0111, "R6 equal");
      drive(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111, "R7 max vs min");
      drive(32'h8000_0000, 32'h0000_0001, 4'b0111, "R7 min vs one");
      drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111, "R7 min vs max");
      drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0011, "R8 code 0011");
      drive(32'h1234_5678, 32'h9ABC_DEF0, 4'b1000, "R8 code 1000");
      drive(32'hFFFF_FFFF, 32'h0000_0000, 4'b1111, "R8 code 1111");

      // Exhaustive sweep of every code on one operand pair
      for (int c = 0; c < 16; c++) begin
         drive(32'h8765_4321, 32'h1357_9BDF, c[3:0], "R8 R9 code sweep");
      end

      // Random vectors, biased toward equal and extreme operands
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] ra, rb;
         int          k;
         ra = $urandom();
         rb = $urandom();
         k  = int'($urandom_range(0, 9));
         if (k == 0) rb = ra;
         if (k == 1) rb = -ra;
         if (k == 2) ra = {~rb[31], 31'h0};
         drive(ra, rb, codes[$urandom_range(0, 7)], "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
      end

      // Drain the scoreboard
      while (sb_q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      finish_run();
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

endmodule